// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small bank of ownership tokens that two independent agents, a left port and a right port, use to coordinate access to a shared resource. Each token records whether it is free, held by the left port, or held by the right port. A port claims or gives back a token by writing to it. It then polls the token by reading it. A read reports the state as a whole byte: all zeros means "you hold it", and all ones means "you do not".

Every port has an active-low semaphore select, an active-low chip enable, a write strobe (low = write phase, high = read), a token address and a data byte. A semaphore access is valid only while the select is low and the chip enable is high. A write is committed on the clock at which the strobe is first seen high after being low, provided the access is valid in that cycle. Requests on the two ports that arrive in the same cycle are resolved in a fixed way, so a token never has two holders. A losing request waits and is served when the holder releases the token.

Top module: `sem_bank`

## Requirements
- R1: The bank holds eight independent tokens, selected by the 3-bit address. An operation on one token never changes the state any other token reports.
- R2: After reset every token is free, and a valid read of any token on either port returns 8'hFF.
- R3: A valid read (select low, chip enable high, strobe high) returns the token's state copied onto all eight data bits: 8'h00 to the holder, and 8'hFF to the other port or when the token is free. When no valid read is in progress, the read data is 8'h00.
- R4: A write is committed on the clock at which the strobe is first sampled high after being sampled low, and only if the access is valid at that clock. Only data bit 0 is used; bits 7..1 have no effect.
- R5: Writing 0 is a request. A free token is granted to the requesting port. If the other port holds the token, the request is recorded as pending. If the requester already holds the token, nothing changes.
- R6: Writing 1 while holding a token releases it. If the other port has a pending request, the token passes directly to that port; otherwise it becomes free.
- R7: Writing 1 without holding the token cancels that port's pending request and leaves the holder unchanged.
- R8: When both ports request a free token in the same cycle, the left port is granted it and the right request stays pending.
- R9: An access with the select and the chip enable both low changes no token state and returns 8'h00 on read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_sel_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left chip enable, active low; must be high for a semaphore access |
| l_wr_n | input | 1 | Left write strobe, low = write phase |
| l_addr | input | 3 | Left token address |
| l_wdata | input | 8 | Left write data; only bit 0 is used |
| l_rdata | output | 8 | Left read data |
| r_sel_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right chip enable, active low; must be high for a semaphore access |
| r_wr_n | input | 1 | Right write strobe, low = write phase |
| r_addr | input | 3 | Right token address |
| r_wdata | input | 8 | Right write data; only bit 0 is used |
| r_rdata | output | 8 | Right read data |

## Verification
The ports can only observe a token through polling, so a corrupted holder value shows up on the next valid read as the wrong byte. Both ports would read 8'h00, or both would read 8'hFF while one of them should hold the token. A lost or stale pending flag stays hidden until the holder releases the token. At that point the waiting port reads 8'hFF instead of 8'h00 in the cycle after the release commits, so the bench reads both ports right after every release and every simultaneous request.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_FREE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_port_ctl.sv
// Access qualification and write-strobe edge detection for one port.
module sem_port_ctl #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              ce_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_go,
  output logic              wr_bit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_act
);
  logic access_ok;
  logic wr_n_q;
  logic unused_hi;

  assign access_ok = ~sel_n & ce_n;
  assign unused_hi = ^wdata[DATA_W-1:1];

  // strobe history register, enable always on
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_n_q <= 1'b1;
    else        wr_n_q <= wr_n;
  end

  always_comb begin
    wr_go   = access_ok & ~wr_n_q & wr_n;
    wr_bit  = wdata[0];
    wr_addr = addr;
    rd_act  = access_ok & wr_n;
  end
endmodule

// File: rtl/sem_flag_cell.sv
// State of one token: holder plus a pending request per port.
module sem_flag_cell
  import sem_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   l_go,
  input  logic   l_bit,
  input  logic   r_go,
  input  logic   r_bit,
  output owner_e owner
);
  owner_e own_q, own_d;
  logic   pl_q, pl_d;
  logic   pr_q, pr_d;
  logic   upd_en;

  assign upd_en = l_go | r_go;

  // left operation applied first, then right on the intermediate result
  always_comb begin
    own_d = own_q;
    pl_d  = pl_q;
    pr_d  = pr_q;
    if (l_go) begin
      if (!l_bit) begin
        if (own_d == OWN_FREE)       own_d = OWN_LEFT;
        else if (own_d == OWN_RIGHT) pl_d  = 1'b1;
      end else if (own_d == OWN_LEFT) begin
        if (pr_d) begin
          own_d = OWN_RIGHT;
          pr_d  = 1'b0;
        end else begin
          own_d = OWN_FREE;
        end
      end else begin
        pl_d = 1'b0;
      end
    end
    if (r_go) begin
      if (!r_bit) begin
        if (own_d == OWN_FREE)      own_d = OWN_RIGHT;
        else if (own_d == OWN_LEFT) pr_d  = 1'b1;
      end else if (own_d == OWN_RIGHT) begin
        if (pl_d) begin
          own_d = OWN_LEFT;
          pl_d  = 1'b0;
        end else begin
          own_d = OWN_FREE;
        end
      end else begin
        pr_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= OWN_FREE;
      pl_q  <= 1'b0;
      pr_q  <= 1'b0;
    end else if (upd_en) begin
      own_q <= own_d;
      pl_q  <= pl_d;
      pr_q  <= pr_d;
    end
  end

  assign owner = own_q;

  // R9 / R1: without a committed write the token state is frozen
  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_go && !r_go) |=> ($stable(own_q) && $stable(pl_q) && $stable(pr_q)));

  // R8: simultaneous requests on a free token go left, right waits
  p_left_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_FREE && l_go && !l_bit && r_go && !r_bit)
      |=> (own_q == OWN_LEFT && pr_q));

  // R6: release by left with right pending hands the token over
  p_handover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_LEFT && pr_q && l_go && l_bit && !r_go) |=> (own_q == OWN_RIGHT));

  // R5: a held token cannot be taken by the other port
  p_no_steal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_LEFT && !l_go) |=> (own_q == OWN_LEFT));

  // R7: a non-holder release leaves the holder in place
  p_cancel_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (own_q == OWN_RIGHT && l_go && l_bit && !r_go) |=> (own_q == OWN_RIGHT && !pl_q));
endmodule

// File: rtl/sem_bank.sv
module sem_bank
  import sem_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 8,
  localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel_n,
  input  logic              l_ce_n,
  input  logic              l_wr_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_sel_n,
  input  logic              r_ce_n,
  input  logic              r_wr_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  logic              l_go, l_bit, l_rd;
  logic              r_go, r_bit, r_rd;
  logic [ADDR_W-1:0] l_waddr, r_waddr;
  owner_e            own [NUM_FLAGS];

  sem_port_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lport (
    .clk(clk), .rst_n(rst_n), .sel_n(l_sel_n), .ce_n(l_ce_n), .wr_n(l_wr_n),
    .addr(l_addr), .wdata(l_wdata), .wr_go(l_go), .wr_bit(l_bit),
    .wr_addr(l_waddr), .rd_act(l_rd)
  );

  sem_port_ctl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rport (
    .clk(clk), .rst_n(rst_n), .sel_n(r_sel_n), .ce_n(r_ce_n), .wr_n(r_wr_n),
    .addr(r_addr), .wdata(r_wdata), .wr_go(r_go), .wr_bit(r_bit),
    .wr_addr(r_waddr), .rd_act(r_rd)
  );

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    logic l_hit, r_hit;
    assign l_hit = l_go && (l_waddr == ADDR_W'(i));
    assign r_hit = r_go && (r_waddr == ADDR_W'(i));
    sem_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .l_go(l_hit), .l_bit(l_bit),
      .r_go(r_hit), .r_bit(r_bit),
      .owner(own[i])
    );
    // R1: exclusive holder encoding per token
    p_legal_owner_r1: assert property (@(posedge clk) disable iff (!rst_n)
      own[i] inside {OWN_FREE, OWN_LEFT, OWN_RIGHT});
  end

  always_comb begin
    l_rdata = l_rd ? {DATA_W{own[l_addr] != OWN_LEFT}}  : '0;
    r_rdata = r_rd ? {DATA_W{own[r_addr] != OWN_RIGHT}} : '0;
  end
endmodule

// File: tb/sem_bank_bench.sv
module sem_bank_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       l_sel_n, l_ce_n, l_wr_n, r_sel_n, r_ce_n, r_wr_n;
  logic [2:0] l_addr, r_addr;
  logic [7:0] l_wdata, r_wdata, l_rdata, r_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct { int port; logic [7:0] exp; string tag; } exp_t;
  exp_t exp_q[$];
  event sample_ev;

  always #5 clk = ~clk;

  sem_bank u_sem_bank (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_ce_n(l_ce_n), .l_wr_n(l_wr_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata),
    .r_sel_n(r_sel_n), .r_ce_n(r_ce_n), .r_wr_n(r_wr_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata)
  );

  // monitor: pops expected items and compares against the port read data
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        exp_t it;
        logic [7:0] act;
        it  = exp_q.pop_front();
        act = (it.port == 0) ? l_rdata : r_rdata;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s port=%0d actual=%h expected=%h", it.tag, it.port, act, it.exp);
        end
      end
    end
  end

  task automatic drive(int p, logic s, logic c, logic w, logic [2:0] a, logic [7:0] d);
    if (p == 0) begin l_sel_n = s; l_ce_n = c; l_wr_n = w; l_addr = a; l_wdata = d; end
    else        begin r_sel_n = s; r_ce_n = c; r_wr_n = w; r_addr = a; r_wdata = d; end
  endtask

  task automatic idle_all();
    drive(0, 1'b1, 1'b1, 1'b1, 3'd0, 8'h00);
    drive(1, 1'b1, 1'b1, 1'b1, 3'd0, 8'h00);
  endtask

  // strobe low for one clock, then high: commits at the following posedge
  task automatic wr(int p, logic [2:0] a, logic [7:0] d, logic ce_lvl = 1'b1);
    @(negedge clk); drive(p, 1'b0, ce_lvl, 1'b0, a, d);
    @(negedge clk); drive(p, 1'b0, ce_lvl, 1'b1, a, d);
    @(negedge clk); idle_all();
  endtask

  task automatic wr_both(logic [2:0] a, logic [7:0] dl, logic [7:0] dr);
    @(negedge clk); drive(0, 1'b0, 1'b1, 1'b0, a, dl); drive(1, 1'b0, 1'b1, 1'b0, a, dr);
    @(negedge clk); drive(0, 1'b0, 1'b1, 1'b1, a, dl); drive(1, 1'b0, 1'b1, 1'b1, a, dr);
    @(negedge clk); idle_all();
  endtask

  task automatic rd(int p, logic [2:0] a, logic [7:0] e, string tag, logic ce_lvl = 1'b1);
    exp_t it;
    @(negedge clk); drive(p, 1'b0, ce_lvl, 1'b1, a, 8'h00);
    it.port = p; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    #1 -> sample_ev;
    #1;
    idle_all();
  endtask

  initial begin
    rst_n = 1'b0;
    idle_all();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    rd(0, 3'd0, 8'hFF, "R2 reset left");
    rd(1, 3'd7, 8'hFF, "R2 reset right");
    rd(0, 3'd3, 8'h00, "R3 idle port data", 1'b0);

    // request with upper data bits set: only bit 0 counts
    wr(0, 3'd2, 8'hFE);
    rd(0, 3'd2, 8'h00, "R5 R4 left granted");
    rd(1, 3'd2, 8'hFF, "R3 other port sees ones");
    wr(1, 3'd2, 8'h00);
    rd(1, 3'd2, 8'hFF, "R5 right pending");
    rd(0, 3'd2, 8'h00, "R5 left keeps token");
    wr(0, 3'd2, 8'h01);
    rd(1, 3'd2, 8'h00, "R6 handover to right");
    rd(0, 3'd2, 8'hFF, "R6 left released");

    wr(0, 3'd2, 8'h00);
    wr(0, 3'd2, 8'h01);
    rd(1, 3'd2, 8'h00, "R7 holder unchanged");
    wr(1, 3'd2, 8'h01);
    rd(0, 3'd2, 8'hFF, "R7 cancelled, no handover");
    rd(1, 3'd2, 8'hFF, "R7 token free");

    wr_both(3'd5, 8'h00, 8'h00);
    rd(0, 3'd5, 8'h00, "R8 left wins");
    rd(1, 3'd5, 8'hFF, "R8 right loses");
    wr(0, 3'd5, 8'hFF);
    rd(1, 3'd5, 8'h00, "R8 right pending served");

    wr(1, 3'd5, 8'h01, 1'b0);
    rd(1, 3'd5, 8'h00, "R9 forbidden release ignored");
    rd(1, 3'd5, 8'h00, "R9 forbidden read zero", 1'b0);
    rd(0, 3'd5, 8'h00, "R9 forbidden read zero left", 1'b0);

    rd(0, 3'd6, 8'hFF, "R1 neighbour free");
    rd(1, 3'd4, 8'hFF, "R1 neighbour free right");

    // select dropped before the strobe rises: no commit
    @(negedge clk); drive(0, 1'b0, 1'b1, 1'b0, 3'd6, 8'h00);
    @(negedge clk); drive(0, 1'b1, 1'b1, 1'b1, 3'd6, 8'h00);
    @(negedge clk); idle_all();
    rd(0, 3'd6, 8'hFF, "R4 no commit without valid rise");

    wr(1, 3'd5, 8'h01);
    rd(1, 3'd5, 8'hFF, "R6 release to free");
    rd(0, 3'd5, 8'hFF, "R6 free for left");

    @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule